// File: doc/BRIEF.md
# Configuration Cycle Address Decoder

This block turns one host-side configuration request into the address phase of a Type 0 configuration cycle on a 32-bit parallel bus. A request carries a device number, a function number, a byte register offset and a read/write flag. The block raises exactly one line in the upper half of the address word as the chip-select for the addressed device. It places the function number and the dword register index in the low bits, and picks the configuration read or write command code.

Devices 0 to 15 are reachable: device N raises address line 16+N. The device field is wider than that range, and a request for a higher device is taken and reported as rejected. It does not start a bus cycle and leaves the address and command outputs as they were.

Requests are taken with a valid/ready handshake. All outputs are registered and change on the clock edge after acceptance. The block drops ready for that one issue cycle, so at most one request is taken every two cycles.

Top module: `cfg_idsel_decoder`

## Requirements
- R1: After reset, `cyc_start` and `cyc_reject` are 0, `cyc_ad` is all zeros, `cyc_cbe` is 4'b0000 and `req_ready` is 1.
- R2: For an accepted request with device N in 0..15, `cyc_ad[16+N]` is 1 and every other bit of `cyc_ad[31:16]` is 0.
- R3: Device 8 selects address line 24, so `cyc_ad[31:16]` equals 16'h0100.
- R4: A request with device above 15 gives a one-cycle `cyc_reject` pulse, no `cyc_start`, and leaves `cyc_ad` and `cyc_cbe` unchanged.
- R5: `cyc_ad[10:8]` carries the 3-bit function number and `cyc_ad[15:11]` is 0.
- R6: `cyc_ad[7:2]` carries `req_reg[7:2]` and `cyc_ad[1:0]` is 2'b00. `req_reg[1:0]` has no effect on any output.
- R7: `cyc_cbe` is 4'b1010 for a read (`req_write`=0) and 4'b1011 for a write (`req_write`=1).
- R8: Outputs update on the first clock edge after the edge where `req_valid && req_ready`. `cyc_start` is high for exactly that one cycle.
- R9: `req_ready` is 0 for the cycle after an acceptance and 1 otherwise. With `req_valid` low, no output changes, whatever the request fields do.
- R10: `cyc_start` and `cyc_reject` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_reg | input | 8 | Byte offset of the configuration register |
| req_write | input | 1 | 1 = configuration write, 0 = configuration read |
| cyc_start | output | 1 | One-cycle pulse: an address phase is ready on `cyc_ad`/`cyc_cbe` |
| cyc_reject | output | 1 | One-cycle pulse: the request was out of range and dropped |
| cyc_ad | output | 32 | Address-phase word |
| cyc_cbe | output | 4 | Command code for the address phase |

## Verification
The bench sweeps every device code 0 to 31, every function number, every dword index and both directions. It varies the byte-lane bits, so a decoder that let those bits leak would put nonzero values in `cyc_ad[1:0]`. An off-by-one range limit would start a cycle for device 16, or reject device 15. Reject handling is checked against the last good address phase, so a design that loaded the register on a rejected request shows a changed word. Separate tests target device 8 on line 24 and the reset state. They also cover the single-cycle start pulse with ready dropping behind it, and idle cycles with changing fields, where a design that ignored `req_valid` would issue spurious cycles.

// File: rtl/cfg_idsel_pkg.sv
// Shared types for the configuration cycle decoder.
// Assumes a 4-bit command/byte-enable bus during the address phase.
package cfg_idsel_pkg;

    // Command codes driven during a configuration address phase.
    typedef enum logic [3:0] {
        CMD_CFG_READ  = 4'b1010,
        CMD_CFG_WRITE = 4'b1011
    } cfg_cmd_e;

    // Address-phase type marker in the two lowest address bits.
    localparam logic [1:0] TYPE0_MARK = 2'b00;

endpackage

// File: rtl/idsel_line_decoder.sv
// Decodes a device number into one select line among the upper address
// bits, and reports whether the device number has a line at all.
// Assumes SEL_LSB < AD_W; the line count is AD_W - SEL_LSB.
module idsel_line_decoder #(
    parameter int DEV_W   = 5,
    parameter int AD_W    = 32,
    parameter int SEL_LSB = 16
) (
    input  logic [DEV_W-1:0]          dev,
    output logic [AD_W-SEL_LSB-1:0]   sel_lines,
    output logic                      in_range
);
    localparam int NUM_LINES = AD_W - SEL_LSB;
    localparam logic [DEV_W:0] LINE_LIMIT = (DEV_W+1)'(NUM_LINES);

    // One comparator per select line.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign sel_lines[i] = (dev == DEV_W'(i));
    end

    // Device numbers past the last line cannot be placed on the bus.
    always_comb begin
        in_range = ({1'b0, dev} < LINE_LIMIT);
    end

endmodule

// File: rtl/cfg_addr_former.sv
// Builds the address-phase word and the command code from the select
// lines, the function number, the register offset and the direction.
// Assumes the function field ends below SEL_LSB. The byte-lane bits of
// the register offset are not part of the address phase.
module cfg_addr_former
    import cfg_idsel_pkg::*;
#(
    parameter int FUNC_W  = 3,
    parameter int REG_W   = 8,
    parameter int AD_W    = 32,
    parameter int SEL_LSB = 16
) (
    input  logic [AD_W-SEL_LSB-1:0] sel_lines,
    input  logic [FUNC_W-1:0]       func,
    input  logic [REG_W-1:0]        regoff,
    input  logic                    write,
    output logic [AD_W-1:0]         ad,
    output logic [3:0]              cbe
);
    localparam int DW_W     = REG_W - 2;
    localparam int FUNC_LSB = 2 + DW_W;

    // Byte-lane bits belong to the data phase and are dropped here.
    logic unused_byte_lane;
    assign unused_byte_lane = ^regoff[1:0];

    // Place every field at its bit position; unused gaps stay zero.
    always_comb begin
        ad                          = '0;
        ad[AD_W-1:SEL_LSB]          = sel_lines;
        ad[FUNC_LSB +: FUNC_W]      = func;
        ad[2 +: DW_W]               = regoff[REG_W-1:2];
        ad[1:0]                     = TYPE0_MARK;
    end

    // Pick the configuration command from the direction flag.
    always_comb begin
        cbe = write ? CMD_CFG_WRITE : CMD_CFG_READ;
    end

endmodule

// File: rtl/cycle_issue_stage.sv
// Registers the decoded address phase on acceptance and produces the
// one-cycle start or reject pulse. Holds the last good address phase
// across rejected requests. Assumes accept is already qualified by ready.
module cycle_issue_stage #(
    parameter int AD_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            in_range,
    input  logic [AD_W-1:0] ad_next,
    input  logic [3:0]      cbe_next,
    output logic            busy,
    output logic            cyc_start,
    output logic            cyc_reject,
    output logic [AD_W-1:0] cyc_ad,
    output logic [3:0]      cyc_cbe
);
    // Pulse flags and the busy marker for the issue cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cyc_start  <= 1'b0;
            cyc_reject <= 1'b0;
        end else begin
            busy       <= accept;
            cyc_start  <= accept && in_range;
            cyc_reject <= accept && !in_range;
        end
    end

    // Address-phase register, loaded only by requests that fit the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_ad  <= '0;
            cyc_cbe <= 4'b0000;
        end else if (accept && in_range) begin
            cyc_ad  <= ad_next;
            cyc_cbe <= cbe_next;
        end
    end

    AST_REJECT_HOLDS_AD: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_reject |-> ($stable(cyc_ad) && $stable(cyc_cbe))); // R4
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !cyc_start); // R8
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_start && cyc_reject)); // R10

endmodule

// File: rtl/cfg_idsel_decoder.sv
// Top of the configuration cycle decoder: takes one request per
// handshake, decodes the device select line, forms the address and
// command, and registers them for the following cycle.
// Assumes the downstream bus logic consumes the start pulse at once.
module cfg_idsel_decoder
    import cfg_idsel_pkg::*;
#(
    parameter int DEV_W   = 5,
    parameter int FUNC_W  = 3,
    parameter int REG_W   = 8,
    parameter int AD_W    = 32,
    parameter int SEL_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [REG_W-1:0]  req_reg,
    input  logic              req_write,
    output logic              cyc_start,
    output logic              cyc_reject,
    output logic [AD_W-1:0]   cyc_ad,
    output logic [3:0]        cyc_cbe
);
    localparam int NUM_LINES = AD_W - SEL_LSB;

    logic [NUM_LINES-1:0] sel_lines;
    logic                 in_range;
    logic [AD_W-1:0]      ad_next;
    logic [3:0]           cbe_next;
    logic                 busy;
    logic                 accept;

    // Ready drops for the issue cycle; acceptance is the handshake.
    always_comb begin
        req_ready = !busy;
        accept    = req_valid && req_ready;
    end

    idsel_line_decoder #(
        .DEV_W   (DEV_W),
        .AD_W    (AD_W),
        .SEL_LSB (SEL_LSB)
    ) u_line_dec (
        .dev       (req_dev),
        .sel_lines (sel_lines),
        .in_range  (in_range)
    );

    cfg_addr_former #(
        .FUNC_W  (FUNC_W),
        .REG_W   (REG_W),
        .AD_W    (AD_W),
        .SEL_LSB (SEL_LSB)
    ) u_former (
        .sel_lines (sel_lines),
        .func      (req_func),
        .regoff    (req_reg),
        .write     (req_write),
        .ad        (ad_next),
        .cbe       (cbe_next)
    );

    cycle_issue_stage #(
        .AD_W (AD_W)
    ) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .in_range   (in_range),
        .ad_next    (ad_next),
        .cbe_next   (cbe_next),
        .busy       (busy),
        .cyc_start  (cyc_start),
        .cyc_reject (cyc_reject),
        .cyc_ad     (cyc_ad),
        .cyc_cbe    (cyc_cbe)
    );

    AST_ONE_SELECT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> ($countones(cyc_ad[AD_W-1:SEL_LSB]) == 1)); // R2
    AST_TYPE0_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> (cyc_ad[1:0] == 2'b00)); // R6
    AST_CONFIG_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> (cyc_cbe[3:1] == 3'b101)); // R7
    AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R9
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !(cyc_start || cyc_reject)); // R9

endmodule

// File: tb/test_cfg_idsel_decoder.sv
`timescale 1ns/1ps
module test_cfg_idsel_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [4:0]  req_dev;
    logic [2:0]  req_func;
    logic [7:0]  req_reg;
    logic        req_write;
    logic        cyc_start;
    logic        cyc_reject;
    logic [31:0] cyc_ad;
    logic [3:0]  cyc_cbe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [31:0] last_ad;
    logic [3:0]  last_cbe;

    always #2 clk = ~clk;

    cfg_idsel_decoder i_cfg_idsel_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_dev(req_dev), .req_func(req_func), .req_reg(req_reg),
        .req_write(req_write), .cyc_start(cyc_start), .cyc_reject(cyc_reject),
        .cyc_ad(cyc_ad), .cyc_cbe(cyc_cbe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Issue one request and check the issue cycle and the cycle after it.
    task automatic issue(input int dev, input int func, input int rg, input bit wr);
        logic [31:0] exp_ad;
        logic [3:0]  exp_cbe;
        bit ok;
        ok = (dev <= 15);
        @(negedge clk);
        chk("R9 ready before request", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_dev   = 5'(dev);
        req_func  = 3'(func);
        req_reg   = 8'(rg);
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (ok) begin
            exp_ad  = (32'd1 << (16 + dev)) | (32'(func) << 8) | (32'(rg) & 32'h0000_00FC);
            exp_cbe = wr ? 4'b1011 : 4'b1010;
            chk("R8 start pulse", {30'b0, cyc_start, cyc_reject}, 32'd2);
            chk("R2 R5 R6 address", cyc_ad, exp_ad);
            chk("R7 command", {28'b0, cyc_cbe}, {28'b0, exp_cbe});
            last_ad  = exp_ad;
            last_cbe = exp_cbe;
        end else begin
            chk("R4 reject pulse", {30'b0, cyc_start, cyc_reject}, 32'd1);
            chk("R4 address held", cyc_ad, last_ad);
            chk("R4 command held", {28'b0, cyc_cbe}, {28'b0, last_cbe});
        end
        chk("R9 ready low in issue cycle", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        chk("R8 pulses end after one cycle", {30'b0, cyc_start, cyc_reject}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_dev = '0; req_func = '0; req_reg = '0; req_write = 1'b0;
        last_ad = '0; last_cbe = 4'b0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", {30'b0, cyc_start, cyc_reject}, 32'd0);
        chk("R1 address", cyc_ad, 32'd0);
        chk("R1 command", {28'b0, cyc_cbe}, 32'd0);
        chk("R1 ready", {31'b0, req_ready}, 32'd1);

        // R4 reject straight after reset keeps reset values
        issue(16, 3, 8'h40, 1'b1);

        // R3 device 8 on line 24
        issue(8, 0, 0, 1'b0);
        chk("R3 line 24", {16'b0, cyc_ad[31:16]}, 32'h0000_0100);

        // R6 byte-lane bits have no effect
        issue(5, 2, 8'h3C, 1'b1);
        issue(5, 2, 8'h3F, 1'b1);
        chk("R6 byte lane ignored", cyc_ad, 32'h0020_023C);

        // R9 idle cycles with moving fields leave outputs alone
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            req_dev = 5'(k * 3); req_func = 3'(k); req_reg = 8'(k * 37); req_write = k[0];
            @(negedge clk);
            chk("R9 idle flags", {30'b0, cyc_start, cyc_reject}, 32'd0);
            chk("R9 idle address", cyc_ad, last_ad);
        end

        // Sweep: every device, function, dword index and both directions
        for (int d = 0; d < 32; d++)
            for (int f = 0; f < 8; f++)
                for (int w = 0; w < 64; w++)
                    issue(d, f, w * 4 + ((d + f) % 4), 1'((w + d) % 2));

        // Boundary pair: last reachable device, then first unreachable one
        issue(15, 7, 8'hFF, 1'b0);
        chk("R2 device 15 line 31", {16'b0, cyc_ad[31:16]}, 32'h0000_8000);
        issue(31, 0, 0, 1'b1);

        summary();
    end
endmodule